// File: doc/BRIEF.md
# Timer Compare Interrupt Unit

The unit keeps a free-running 63-bit tick counter and two 64-bit compare words, one owned by the supervisor and one by the hypervisor. Each compare word holds a disable flag in its top bit and a 63-bit target below it. A write to a compare word arms a one-shot match, but only if the flag is clear and the target lies strictly ahead of the counter value at the time of the write. When the counter reaches an armed target, the slot raises a one-cycle strobe and disarms itself.

The supervisor strobe sets the timer bit of a 17-bit soft-interrupt register. Software can also write, set or clear the bits of that register. The hypervisor strobe sets a pending flag, and the hypervisor interrupt output follows that flag until software writes it to zero. Software reaches every register through one address/data port. Writes take effect at the clock edge, and reads return data combinationally.

Top module: `tick_match_intc`

## Requirements
- R1: The tick counter resets to 0 and advances by one every clock, wrapping from 2^63-1 to 0. A read at address 0 returns it zero-extended to 64 bits.
- R2: A write to address 0 loads bits 62:0 into the counter. The loaded value is readable in the cycle after the write edge, and counting resumes from that value.
- R3: A write to a compare word with bit 63 set cancels any armed match for that slot. No strobe and no interrupt follow until the slot is written again.
- R4: A write arms a match only when the target (bits 62:0) is strictly greater than the counter value in the write cycle. A target equal to or below that value never fires.
- R5: An armed slot raises its strobe (sup_match_o for the supervisor word at address 1, hyp_match_o for the hypervisor word at address 2) for exactly one cycle. That cycle is the one in which the counter equals the target. The slot then stays disarmed, even if the counter reaches the target again.
- R6: Rewriting an armed compare word replaces the pending match. Only the new target can fire.
- R7: A supervisor strobe sets bit 16 of the soft-interrupt register at the following edge and leaves bits 15:0 unchanged.
- R8: In the soft-interrupt register (soft_int_o, 17 bits), a write to address 3 replaces the value. A write to address 4 ORs data bits 16:0 in, and a write to address 5 clears the bits that are set in the data. A read at address 3 returns the register.
- R9: A hypervisor strobe sets the pending flag (address 6, bit 0) at the following edge. hyp_irq_o is high exactly while the flag is 1. A software write of 0 clears the flag.
- R10: A compare word reads back exactly as last written, including bit 63. After reset each compare word reads 64'h8000_0000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| soft_int_o | output | 17 | Soft-interrupt register contents |
| sup_match_o | output | 1 | One-cycle supervisor match strobe |
| hyp_match_o | output | 1 | One-cycle hypervisor match strobe |
| hyp_irq_o | output | 1 | Hypervisor interrupt, high while pending flag set |

## Verification
A stale arm flag shows at the ports as a strobe in a cycle where none is due. Such a strobe appears at the wrong target or a second time, and the scoreboard catches it in the cycle the counter meets the old target. A lost arm shows as a missing strobe, which is detected when the expected queue is still non-empty at the end. A wrong arming comparison (off by one on the strict-future rule) shows as a strobe on an equal target. Errors in the soft or pending registers appear one edge after a strobe or a write, at soft_int_o, hyp_irq_o and the read port.

// File: rtl/tmi_pkg.sv
package tmi_pkg;
  localparam int TICK_W       = 63;
  localparam int SOFT_W       = 17;
  localparam int SOFT_TMR_BIT = 16;
  localparam int ADDR_W       = 3;

  localparam logic [ADDR_W-1:0] A_TICK  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SCMP  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HCMP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SOFT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_SSET  = 3'd4;
  localparam logic [ADDR_W-1:0] A_SCLR  = 3'd5;
  localparam logic [ADDR_W-1:0] A_HPEND = 3'd6;

  typedef enum logic [0:0] { SLOT_SUP = 1'b0, SLOT_HYP = 1'b1 } slot_e;
endpackage

// File: rtl/tmi_tick_counter.sv
module tmi_tick_counter #(
  parameter int TICK_W = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TICK_W-1:0] load_val,
  output logic [TICK_W-1:0] cnt_q
);
  function automatic logic [TICK_W-1:0] next_tick(input logic [TICK_W-1:0] v);
    return v + TICK_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else           cnt_q <= next_tick(cnt_q);
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt_q == $past(cnt_q) + TICK_W'(1));
  a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/tmi_compare_slot.sv
module tmi_compare_slot #(
  parameter int TICK_W = 63
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [TICK_W:0] wdata,
  input  logic [TICK_W-1:0] cnt,
  output logic [TICK_W:0] cmp_q,
  output logic            armed_q,
  output logic            hit
);
  localparam int CMP_W = TICK_W + 1;

  function automatic logic word_disabled(input logic [CMP_W-1:0] w);
    return w[CMP_W-1];
  endfunction

  function automatic logic [TICK_W-1:0] word_target(input logic [CMP_W-1:0] w);
    return w[TICK_W-1:0];
  endfunction

  // target - now as a signed value one bit wider; arms only if > 0
  function automatic logic arm_ok(input logic [CMP_W-1:0] w,
                                  input logic [TICK_W-1:0] now);
    logic [CMP_W-1:0] diff;
    diff = {1'b0, word_target(w)} - {1'b0, now};
    return !word_disabled(w) && !diff[CMP_W-1] && (diff != '0);
  endfunction

  logic target_eq;
  assign target_eq = (word_target(cmp_q) == cnt);
  // a write to this slot in the same cycle supersedes the old match
  assign hit = armed_q && target_eq && !word_disabled(cmp_q) && !wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= {1'b1, {TICK_W{1'b0}}};
      armed_q <= 1'b0;
    end else if (wr) begin
      cmp_q   <= wdata;
      armed_q <= arm_ok(wdata, cnt);
    end else if (hit) begin
      armed_q <= 1'b0;
    end
  end

  a_r5_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !armed_q && !hit);
  a_r3_disable_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[TICK_W]) |=> !armed_q && !hit);
  a_r4_no_arm_past: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (wdata[TICK_W-1:0] <= cnt)) |=> !armed_q);
  a_r10_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cmp_q == $past(wdata));
endmodule

// File: rtl/tmi_softint_reg.sv
module tmi_softint_reg #(
  parameter int SOFT_W  = 17,
  parameter int TMR_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_val,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [SOFT_W-1:0] wdata,
  input  logic              tmr_hit,
  output logic [SOFT_W-1:0] soft_q
);
  localparam logic [SOFT_W-1:0] TMR_MASK = SOFT_W'(1) << TMR_BIT;

  logic [SOFT_W-1:0] sw_next;
  always_comb begin
    if (wr_val)      sw_next = wdata;
    else if (wr_set) sw_next = soft_q | wdata;
    else if (wr_clr) sw_next = soft_q & ~wdata;
    else             sw_next = soft_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_q <= '0;
    else        soft_q <= sw_next | (tmr_hit ? TMR_MASK : '0);
  end

  a_r7_timer_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_hit |=> soft_q[TMR_BIT]);
  a_r7_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_hit && !wr_val && !wr_set && !wr_clr) |=>
      soft_q[TMR_BIT-1:0] == $past(soft_q[TMR_BIT-1:0]));
  a_r8_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_val && !wr_set && !tmr_hit) |=> (soft_q & $past(wdata)) == '0);
endmodule

// File: rtl/tmi_hyp_pend.sv
module tmi_hyp_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit,
  input  logic hit,
  output logic pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (hit) pend_q <= 1'b1;
    else if (wr)  pend_q <= wbit;
  end

  a_r9_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_q);
  a_r9_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wbit && !hit) |=> !pend_q);
endmodule

// File: rtl/tick_match_intc.sv
module tick_match_intc
  import tmi_pkg::*;
#(
  parameter int CNT_W = tmi_pkg::TICK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [2:0]   reg_addr,
  input  logic [63:0]  reg_wdata,
  output logic [63:0]  reg_rdata,
  output logic [16:0]  soft_int_o,
  output logic         sup_match_o,
  output logic         hyp_match_o,
  output logic         hyp_irq_o
);
  localparam int CMP_W = CNT_W + 1;
  localparam int NSLOT = 2;

  logic [CNT_W-1:0] cnt;
  logic [NSLOT-1:0] slot_wr, slot_hit, slot_armed;
  logic [CMP_W-1:0] slot_cmp [NSLOT];
  logic [SOFT_W-1:0] soft_q;
  logic hpend_q;

  function automatic logic addr_wr(input logic we, input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] tgt);
    return we && (a == tgt);
  endfunction

  tmi_tick_counter #(.TICK_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n),
    .load(addr_wr(reg_wr, reg_addr, A_TICK)),
    .load_val(reg_wdata[CNT_W-1:0]),
    .cnt_q(cnt)
  );

  assign slot_wr[SLOT_SUP] = addr_wr(reg_wr, reg_addr, A_SCMP);
  assign slot_wr[SLOT_HYP] = addr_wr(reg_wr, reg_addr, A_HCMP);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    tmi_compare_slot #(.TICK_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr(slot_wr[s]), .wdata(reg_wdata[CMP_W-1:0]), .cnt(cnt),
      .cmp_q(slot_cmp[s]), .armed_q(slot_armed[s]), .hit(slot_hit[s])
    );
  end

  tmi_softint_reg #(.SOFT_W(SOFT_W), .TMR_BIT(SOFT_TMR_BIT)) u_soft (
    .clk(clk), .rst_n(rst_n),
    .wr_val(addr_wr(reg_wr, reg_addr, A_SOFT)),
    .wr_set(addr_wr(reg_wr, reg_addr, A_SSET)),
    .wr_clr(addr_wr(reg_wr, reg_addr, A_SCLR)),
    .wdata(reg_wdata[SOFT_W-1:0]),
    .tmr_hit(slot_hit[SLOT_SUP]),
    .soft_q(soft_q)
  );

  tmi_hyp_pend u_hpend (
    .clk(clk), .rst_n(rst_n),
    .wr(addr_wr(reg_wr, reg_addr, A_HPEND)),
    .wbit(reg_wdata[0]),
    .hit(slot_hit[SLOT_HYP]),
    .pend_q(hpend_q)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TICK:  reg_rdata = 64'(cnt);
      A_SCMP:  reg_rdata = 64'(slot_cmp[SLOT_SUP]);
      A_HCMP:  reg_rdata = 64'(slot_cmp[SLOT_HYP]);
      A_SOFT:  reg_rdata = 64'(soft_q);
      A_HPEND: reg_rdata = 64'(hpend_q);
      default: reg_rdata = '0;
    endcase
  end

  assign soft_int_o  = soft_q;
  assign sup_match_o = slot_hit[SLOT_SUP];
  assign hyp_match_o = slot_hit[SLOT_HYP];
  assign hyp_irq_o   = hpend_q;

  a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hyp_irq_o) |-> $past(hyp_match_o) || $past(addr_wr(reg_wr, reg_addr, A_HPEND)));
  a_r5_strobes_exclusive_arm: assert property (@(posedge clk) disable iff (!rst_n)
    sup_match_o |=> !sup_match_o);
endmodule

// File: tb/tick_match_intc_tb_top.sv
`timescale 1ns/1ps
module tick_match_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [16:0] soft_int_o;
  logic        sup_match_o, hyp_match_o, hyp_irq_o;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  typedef struct { int c; bit hyp; } ev_t;
  ev_t exp_q[$];

  tick_match_intc dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .soft_int_o(soft_int_o),
    .sup_match_o(sup_match_o), .hyp_match_o(hyp_match_o), .hyp_irq_o(hyp_irq_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // monitor: compare observed strobes against the scoreboard queue (R5, R6, R3, R4)
  task automatic take_strobe(input bit hyp);
    ev_t e;
    if (exp_q.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL R5 unexpected strobe actual=cyc%0d/hyp%0d expected=none", cyc, hyp);
    end else begin
      e = exp_q.pop_front();
      chk("R5 strobe cycle/slot", 64'((cyc << 1) | int'(hyp)), 64'((e.c << 1) | int'(e.hyp)));
    end
  endtask

  initial forever begin
    @(negedge clk);
    #2.0;
    if (rst_n) begin
      if (sup_match_o) take_strobe(1'b0);
      if (hyp_match_o) take_strobe(1'b1);
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); #0.2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #0.2;
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk); #0.2;
    reg_wr = 1'b0; reg_addr = a;
    #0.3;
    d = reg_rdata;
  endtask

  // read the counter, then write target = now + off in the same cycle
  task automatic arm(input bit hyp, input bit dis, input longint off,
                     input bit expect_fire, output logic [63:0] word, output int ecyc);
    logic [62:0] now, tgt;
    int k;
    @(negedge clk); #0.2;
    reg_wr = 1'b0; reg_addr = 3'd0;
    #0.3;
    now = reg_rdata[62:0];
    k = cyc;
    tgt = now + off[62:0];
    word = {dis, tgt};
    reg_addr = hyp ? 3'd2 : 3'd1;
    reg_wdata = word;
    reg_wr = 1'b1;
    ecyc = k + int'(off);
    if (expect_fire) exp_q.push_back('{ecyc, hyp});
    @(posedge clk); #0.2;
    reg_wr = 1'b0;
  endtask

  task automatic goto_cyc(input int c);
    while (cyc < c) @(negedge clk);
    #0.5;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary_and_end();
  end

  initial begin
    logic [63:0] d, w;
    int ec, ec2;
    repeat (3) @(posedge clk);
    // reset state (R1, R10, R8, R9)
    rd_reg(3'd0, d); chk("R1 reset counter", d, 64'd0);
    rd_reg(3'd1, d); chk("R10 reset sup compare", d, 64'h8000_0000_0000_0000);
    rd_reg(3'd2, d); chk("R10 reset hyp compare", d, 64'h8000_0000_0000_0000);
    rd_reg(3'd3, d); chk("R8 reset soft", d, 64'd0);
    chk("R9 reset irq", 64'(hyp_irq_o), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 load, R1 increment and wrap
    wr_reg(3'd0, 64'd100);
    rd_reg(3'd0, d); chk("R2 loaded value", d, 64'd100);
    rd_reg(3'd0, d); chk("R1 increment", d, 64'd101);
    wr_reg(3'd0, 64'h7FFF_FFFF_FFFF_FFFF);
    rd_reg(3'd0, d); chk("R2 load max", d, 64'h7FFF_FFFF_FFFF_FFFF);
    rd_reg(3'd0, d); chk("R1 wrap", d, 64'd0);

    // R5/R7 supervisor fire sets bit 16, low bits kept
    wr_reg(3'd3, 64'h5);
    arm(1'b0, 1'b0, 6, 1'b1, w, ec);
    rd_reg(3'd1, d); chk("R10 readback armed", d, w);
    goto_cyc(ec + 1);
    chk("R7 soft after fire", 64'(soft_int_o), 64'h10005);
    rd_reg(3'd3, d); chk("R7 soft read", d, 64'h10005);

    // R8 set / clear / write
    wr_reg(3'd4, 64'h2);
    rd_reg(3'd3, d); chk("R8 set", d, 64'h10007);
    wr_reg(3'd5, 64'h10001);
    rd_reg(3'd3, d); chk("R8 clear", d, 64'h6);
    wr_reg(3'd3, 64'h0);
    rd_reg(3'd3, d); chk("R8 write", d, 64'h0);

    // R9 hypervisor pending and irq
    arm(1'b1, 1'b0, 4, 1'b1, w, ec);
    goto_cyc(ec + 1);
    chk("R9 irq after fire", 64'(hyp_irq_o), 64'd1);
    rd_reg(3'd6, d); chk("R9 pend read", d, 64'd1);
    wr_reg(3'd6, 64'd0);
    chk("R9 irq cleared", 64'(hyp_irq_o), 64'd0);
    rd_reg(3'd6, d); chk("R9 pend cleared", d, 64'd0);

    // R3 disable flag cancels armed match
    arm(1'b0, 1'b0, 5, 1'b0, w, ec);
    arm(1'b0, 1'b1, 3, 1'b0, w, ec2);
    rd_reg(3'd1, d); chk("R10 readback with bit 63", d, w);
    goto_cyc(ec + 8);
    rd_reg(3'd3, d); chk("R3 no soft bit", d, 64'd0);

    // R4 equal and past targets never fire
    arm(1'b0, 1'b0, 0, 1'b0, w, ec);
    arm(1'b1, 1'b0, -5, 1'b0, w, ec2);
    goto_cyc(ec + 12);
    rd_reg(3'd3, d); chk("R4 no soft bit", d, 64'd0);
    chk("R4 no hyp irq", 64'(hyp_irq_o), 64'd0);

    // R6 rewrite replaces pending target
    arm(1'b0, 1'b0, 20, 1'b0, w, ec);
    arm(1'b0, 1'b0, 8, 1'b1, w, ec2);
    goto_cyc(ec + 6);
    rd_reg(3'd3, d); chk("R6 fired once", d, 64'h10000);

    // R5 one fire per arming: counter re-crosses target, no new strobe
    wr_reg(3'd0, {1'b0, w[62:0]} - 64'd3);
    repeat (8) @(negedge clk);
    #0.5;
    chk("R5 scoreboard drained", 64'(exp_q.size()), 64'd0);
    summary_and_end();
  end
endmodule